// File: doc/BRIEF.md
# Rotating-Start Packet Round-Robin Link Scheduler

This block decides which of several per-flow queues may place its head packet on one shared output link. Each queue presents a flag that says it holds at least one packet and the length of its head packet, counted in link slots. One slot is one clock. The block answers with a one-hot grant, a single dequeue strobe and a link-busy flag. The queue named by the grant sends one segment per slot. The dequeue strobe marks the slot that carries the last segment, and the queue pops its head on that clock edge.

Service runs in cycles. A cycle visits every queue once in ring order and takes at most one packet from each queue that has one. A queue found empty costs no slot. The position where a cycle begins moves one step around the ring after every completed cycle. No queue therefore stays first, or last, in the order. A packet longer than one slot keeps the link until it is finished, so arbitration happens per packet and not per clock.

When the link is free and some queue holds a packet, the decision is made in the same slot, so the link never idles while work is waiting. The packet buffers themselves sit outside the block.

Top module: `rrs_sched`

## Requirements
- R1: `grant` has at most one bit set. It is all zero in any slot where no segment is sent.
- R2: Within a service cycle, queues are visited in ascending index order, wrapping from NQ-1 to 0, starting at the cycle's start queue. Each queue provides at most one packet per cycle. Empty queues are passed over without using a slot. A cycle is complete once its last position has been visited.
- R3: The first cycle after reset starts at queue 0. Each following cycle starts one index above the previous start, wrapping modulo NQ.
- R4: A packet of length n (n >= 1, in slots, read from the queue's `q_len` field while the link is free) holds the grant on its queue for exactly n consecutive slots. No other queue is granted during those slots.
- R5: `deq_strobe` is high for exactly one slot per packet, the slot carrying its last segment, and only while a grant is present. A one-slot packet raises it in the slot in which it is granted.
- R6: If no packet is in progress and at least one `q_nonempty` bit is set, a grant is issued in that same slot.
- R7: A packet that reaches a queue already passed in the current cycle is not served before the next cycle, provided some later queue in the current cycle has a packet.
- R8: After synchronous reset, with empty queues, `grant`, `deq_strobe` and `link_busy` are all zero.
- R9: With NQ queues continuously backlogged with one-slot packets, every NQ*NQ consecutive slots give each queue exactly NQ slots.
- R10: `link_busy` is high in exactly the slots where a segment is sent, that is, whenever `grant` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous reset, active high |
| q_nonempty | input | NQ | Bit i set when queue i holds a packet |
| q_len | input | NQ*LEN_W | Head packet length in slots, queue i at bits [i*LEN_W +: LEN_W] |
| grant | output | NQ | One-hot selection of the queue sending this slot |
| deq_strobe | output | 1 | Last segment of the granted packet is sent this slot |
| link_busy | output | 1 | A segment is on the link this slot |

## Verification
Every non-empty subset of four single-slot queues is applied straight after reset. This separates the fixed start at queue 0 from any other choice of first winner. A full backlog with one-slot packets exposes the rotation, because every cycle's order must be shifted by one from the previous cycle's order, and it also gives the per-queue share. Mixed packet lengths check that the link is held and that the strobe lands on the last slot. A late arrival at a queue already passed tells deferral to the next cycle apart from plain index priority. A long pseudo-random run with arrivals of varying length compares every slot against a slot-level model of the cycle rules.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
   // Where the winning packet comes from in a free slot
   typedef enum logic [1:0] {
      PICK_NONE = 2'd0,
      PICK_THIS = 2'd1,
      PICK_NEXT = 2'd2
   } pick_src_e;
endpackage

// File: rtl/rrs_pick.sv
// First requesting position, in ring order from base, at or after min_off.
module rrs_pick #(
   parameter int NQ    = 4,
   parameter int IDX_W = 2
) (
   input  logic [NQ-1:0]    req,
   input  logic [IDX_W-1:0] base,
   input  logic [IDX_W-1:0] min_off,
   output logic             found,
   output logic [IDX_W-1:0] off,
   output logic [IDX_W-1:0] idx
);
   logic [IDX_W-1:0] pos_idx [NQ];
   logic [NQ-1:0]    cand;

   for (genvar o = 0; o < NQ; o++) begin : g_ring
      logic [IDX_W:0] sum;
      assign sum        = {1'b0, base} + (IDX_W+1)'(o);
      assign pos_idx[o] = (sum >= (IDX_W+1)'(NQ)) ? IDX_W'(sum - (IDX_W+1)'(NQ))
                                                  : sum[IDX_W-1:0];
      assign cand[o]    = req[pos_idx[o]] && (IDX_W'(o) >= min_off);
   end

   always_comb begin
      found = 1'b0;
      off   = '0;
      for (int o = NQ - 1; o >= 0; o--) begin
         if (cand[o]) begin
            found = 1'b1;
            off   = IDX_W'(o);
         end
      end
   end

   assign idx = pos_idx[off];
endmodule

// File: rtl/rrs_slot_cnt.sv
// Counts the remaining slots of a packet that spans more than one slot.
module rrs_slot_cnt #(
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [LEN_W-1:0] len,
   output logic             holding,
   output logic             last
);
   logic [LEN_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         holding <= 1'b0;
         cnt     <= '0;
      end else if (holding) begin
         if (cnt == LEN_W'(1)) holding <= 1'b0;
         else                  cnt     <= cnt - 1'b1;
      end else if (load) begin
         holding <= 1'b1;
         cnt     <= len - 1'b1;
      end
   end

   assign last = holding && (cnt == LEN_W'(1));
endmodule

// File: rtl/rrs_sched.sv
module rrs_sched #(
   parameter int NQ    = 4,
   parameter int LEN_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NQ-1:0]     q_nonempty,
   input  logic [NQ*LEN_W-1:0] q_len,
   output logic [NQ-1:0]     grant,
   output logic              deq_strobe,
   output logic              link_busy
);
   import rrs_pkg::*;

   localparam int IDX_W = (NQ > 1) ? $clog2(NQ) : 1;

   if (NQ < 2) begin : g_bad_nq
      $error("rrs_sched: NQ must be at least 2");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("rrs_sched: LEN_W must be at least 1");
   end

   function automatic logic [IDX_W-1:0] inc_wrap(input logic [IDX_W-1:0] v);
      return (v == IDX_W'(NQ - 1)) ? '0 : v + 1'b1;
   endfunction

   logic [IDX_W-1:0] start_q, off_q, cur_q, start_nx;
   logic             fa, fb;
   logic [IDX_W-1:0] oa, ia, ob, ib;
   pick_src_e        src;
   logic [IDX_W-1:0] sel_s, sel_o, sel_i, gnt_idx;
   logic [LEN_W-1:0] sel_len;
   logic             sel_valid, multi, holding, last;

   assign start_nx = inc_wrap(start_q);

   rrs_pick #(.NQ(NQ), .IDX_W(IDX_W)) u_pick_this (
      .req(q_nonempty), .base(start_q), .min_off(off_q),
      .found(fa), .off(oa), .idx(ia));

   rrs_pick #(.NQ(NQ), .IDX_W(IDX_W)) u_pick_next (
      .req(q_nonempty), .base(start_nx), .min_off('0),
      .found(fb), .off(ob), .idx(ib));

   always_comb begin
      if (holding)  src = PICK_NONE;
      else if (fa)  src = PICK_THIS;
      else if (fb)  src = PICK_NEXT;
      else          src = PICK_NONE;
      sel_s = (src == PICK_THIS) ? start_q : start_nx;
      sel_o = (src == PICK_THIS) ? oa : ob;
      sel_i = (src == PICK_THIS) ? ia : ib;
   end

   assign sel_valid = (src != PICK_NONE);
   assign sel_len   = q_len[sel_i*LEN_W +: LEN_W];
   assign multi     = sel_len > LEN_W'(1);

   rrs_slot_cnt #(.LEN_W(LEN_W)) u_cnt (
      .clk(clk), .rst(rst), .load(sel_valid && multi), .len(sel_len),
      .holding(holding), .last(last));

   assign gnt_idx = holding ? cur_q : sel_i;

   always_comb begin
      grant = '0;
      if (holding || sel_valid) grant[gnt_idx] = 1'b1;
   end

   assign deq_strobe = holding ? last : (sel_valid && !multi);
   assign link_busy  = holding || sel_valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         start_q <= '0;
         off_q   <= '0;
         cur_q   <= '0;
      end else if (sel_valid) begin
         cur_q <= sel_i;
         if (sel_o == IDX_W'(NQ - 1)) begin
            start_q <= inc_wrap(sel_s);
            off_q   <= '0;
         end else begin
            start_q <= sel_s;
            off_q   <= sel_o + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rrs_sched_chk.sv
module rrs_sched_chk #(
   parameter int NQ = 4
) (
   input logic          clk,
   input logic          rst,
   input logic [NQ-1:0] q_nonempty,
   input logic [NQ-1:0] grant,
   input logic          deq_strobe,
   input logic          holding
);
   assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant));

   assert_eligible_R2: assert property (@(posedge clk) disable iff (rst)
      (!holding && |grant) |-> ((grant & ~q_nonempty) == '0));

   assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (|grant && !deq_strobe) |=> (grant == $past(grant)));

   assert_deq_grant_R5: assert property (@(posedge clk) disable iff (rst)
      deq_strobe |-> |grant);

   assert_deq_release_R5: assert property (@(posedge clk) disable iff (rst)
      (deq_strobe && holding) |=> !holding);

   assert_work_R6: assert property (@(posedge clk) disable iff (rst)
      (!holding && |q_nonempty) |-> |grant);
endmodule

bind rrs_sched rrs_sched_chk #(.NQ(NQ)) u_chk (
   .clk(clk), .rst(rst), .q_nonempty(q_nonempty), .grant(grant),
   .deq_strobe(deq_strobe), .holding(holding));

// File: tb/rrs_sched_bench.sv
module rrs_sched_bench;
   localparam int NQ    = 4;
   localparam int LEN_W = 4;
   localparam int DEPTH = 64;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [NQ-1:0]     q_nonempty = '0;
   logic [NQ*LEN_W-1:0] q_len = '0;
   logic [NQ-1:0]     grant;
   logic              deq_strobe, link_busy;

   always #10 clk = ~clk;

   rrs_sched #(.NQ(NQ), .LEN_W(LEN_W)) u_rrs_sched (
      .clk(clk), .rst(rst), .q_nonempty(q_nonempty), .q_len(q_len),
      .grant(grant), .deq_strobe(deq_strobe), .link_busy(link_busy));

   int n_chk = 0, n_fail = 0;
   int qd [NQ][DEPTH];
   int qh [NQ];
   int qt [NQ];
   int m_start, m_off, m_cur, m_rem, act_g;
   bit m_hold;

   task automatic chk(input bit ok, input string r, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
      end
   endtask

   task automatic push(input int q, input int len);
      if (qt[q] - qh[q] < DEPTH) begin
         qd[q][qt[q] % DEPTH] = len;
         qt[q]++;
      end
   endtask

   function automatic bit ne(input int q);
      return qt[q] > qh[q];
   endfunction

   function automatic int head(input int q);
      return qd[q][qh[q] % DEPTH];
   endfunction

   task automatic drive();
      for (int q = 0; q < NQ; q++) begin
         q_nonempty[q] = ne(q);
         q_len[q*LEN_W +: LEN_W] = ne(q) ? LEN_W'(head(q)) : '0;
      end
   endtask

   task automatic do_reset();
      for (int q = 0; q < NQ; q++) begin qh[q] = 0; qt[q] = 0; end
      m_start = 0; m_off = 0; m_hold = 0; m_cur = 0; m_rem = 0;
      rst = 1'b1;
      @(negedge clk); drive();
      repeat (2) @(posedge clk);
      @(negedge clk); rst = 1'b0;
   endtask

   // One slot: drive, compare against the slot model, advance the model.
   task automatic slot(input string r);
      int eg, fs, fo, len;
      bit ed, found;
      @(negedge clk); drive();
      #5;
      eg = -1; ed = 0; found = 0; fs = 0; fo = 0;
      if (m_hold) begin
         eg = m_cur; ed = (m_rem == 1);
      end else begin
         for (int k = m_off; k < NQ && !found; k++)
            if (ne((m_start + k) % NQ)) begin found = 1; fs = m_start; fo = k; end
         for (int k = 0; k < NQ && !found; k++)
            if (ne((m_start + 1 + k) % NQ)) begin
               found = 1; fs = (m_start + 1) % NQ; fo = k;
            end
         if (found) begin eg = (fs + fo) % NQ; ed = (head(eg) <= 1); end
      end
      act_g = -1;
      for (int q = 0; q < NQ; q++) if (grant[q]) act_g = q;
      chk(grant == ((eg < 0) ? NQ'(0) : NQ'(1) << eg), r, "grant vector",
          int'(grant), (eg < 0) ? 0 : (1 << eg));
      chk(deq_strobe == ed, "R5", "deq_strobe", int'(deq_strobe), int'(ed));
      chk(link_busy == (eg >= 0), "R10", "link_busy", int'(link_busy), int'(eg >= 0));
      if (m_hold) begin
         if (m_rem == 1) m_hold = 0; else m_rem--;
      end else if (found) begin
         if (fo == NQ - 1) begin m_start = (fs + 1) % NQ; m_off = 0; end
         else begin m_start = fs; m_off = fo + 1; end
         len = head(eg);
         if (len > 1) begin m_hold = 1; m_cur = eg; m_rem = len - 1; end
      end
      if (ed) qh[eg]++;
   endtask

   initial begin : watchdog
      #(200000 * 20);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int cnt [NQ];
      int lowest, seq_ok, lfsr;
      do_reset();
      // R8: idle after reset
      #5;
      chk(grant == '0, "R8", "grant after reset", int'(grant), 0);
      chk(!deq_strobe && !link_busy, "R8", "strobe/busy after reset",
          int'({deq_strobe, link_busy}), 0);
      slot("R1");

      // R3: every request pattern straight after reset; first winner is lowest index
      for (int p = 1; p < (1 << NQ); p++) begin
         do_reset();
         for (int q = 0; q < NQ; q++) if (p[q]) push(q, 1);
         lowest = -1;
         for (int q = NQ - 1; q >= 0; q--) if (p[q]) lowest = q;
         slot("R2");
         chk(act_g == lowest, "R3", "first winner after reset", act_g, lowest);
         repeat (NQ) slot("R2");
      end

      // R3, R9: full backlog of one-slot packets, rotating start
      do_reset();
      for (int q = 0; q < NQ; q++) begin
         cnt[q] = 0;
         for (int j = 0; j < NQ + 2; j++) push(q, 1);
      end
      for (int s = 0; s < NQ * NQ; s++) begin
         slot("R2");
         chk(act_g == ((s / NQ) + (s % NQ)) % NQ, "R3", "rotated order",
             act_g, ((s / NQ) + (s % NQ)) % NQ);
         if (act_g >= 0) cnt[act_g]++;
      end
      for (int q = 0; q < NQ; q++)
         chk(cnt[q] == NQ, "R9", "share per queue", cnt[q], NQ);

      // R4: multi-slot packets hold the link
      do_reset();
      push(0, 3); push(1, 2); push(2, 1);
      seq_ok = 1;
      for (int s = 0; s < 6; s++) begin
         slot("R4");
         if (act_g != ((s < 3) ? 0 : (s < 5) ? 1 : 2)) seq_ok = 0;
      end
      chk(seq_ok == 1, "R4", "hold sequence 0,0,0,1,1,2", seq_ok, 1);
      slot("R1");
      chk(act_g == -1, "R1", "idle after drain", act_g, -1);

      // R7: late arrival at a passed queue waits for the next cycle
      do_reset();
      push(2, 1);
      slot("R7");
      chk(act_g == 2, "R7", "first grant", act_g, 2);
      push(1, 1); push(3, 1);
      slot("R7");
      chk(act_g == 3, "R7", "later queue served first", act_g, 3);
      slot("R7");
      chk(act_g == 1, "R7", "passed queue next cycle", act_g, 1);

      // R6: a single backlogged queue is served every slot
      do_reset();
      for (int j = 0; j < 5; j++) push(1, 1);
      seq_ok = 1;
      for (int s = 0; s < 5; s++) begin
         slot("R6");
         if (act_g != 1) seq_ok = 0;
      end
      chk(seq_ok == 1, "R6", "back-to-back grants", seq_ok, 1);

      // Pseudo-random arrivals with mixed lengths, every slot compared
      do_reset();
      lfsr = 16'hACE1;
      for (int s = 0; s < 3000; s++) begin
         for (int q = 0; q < NQ; q++) begin
            lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
            if ((lfsr & 7) == 0) push(q, 1 + ((lfsr >> 4) & 3));
         end
         slot("R2");
      end

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule